// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This block generates four independent pulse-width modulated outputs from a single clock. Each channel has its own prescaler, a high-time count and a period count. One output period lasts (prescale+1) × period_count clock cycles. The output is high for the first (prescale+1) × duty_count cycles of each period. Software sets up a channel through a small synchronous register bus and then sets the channel's enable bit. A global master bit must also be set before any channel drives its pin.

Each channel's settings are copied into a shadow set at the start of every period. A value written while the channel runs therefore takes effect only at the next period boundary, and no pulse is ever cut short or stretched. When a channel loses its enable, or the master bit is cleared, that channel's pin drops low and its counters return to zero. When it is enabled again, it starts a fresh period that begins with the high phase.

Top module: `pwm_multi`

## Requirements
- R1: After reset, every mapped register reads zero and all four outputs are low.
- R2: Channel n (0..3) has its control word at byte address n×16, its duty count at n×16+4 and its period count at n×16+8. The master word is at address 60. Bits 15:0 of the control, duty and period words read back exactly as written, and bits 31:16 read zero. The master word reads back only bit 0.
- R3: In the control word, bit 0 is the channel enable and bits 15:2 hold the prescale value (0..16383).
- R4: With a channel running, the distance between rising edges of its output is (prescale+1) × period_count cycles.
- R5: Within each period the output is high for (prescale+1) × duty_count cycles, and a newly started channel begins with its high phase.
- R6: A channel drives its output only while both the master bit and its own enable bit are 1. One cycle after either bit clears, the output is low. It stays low until both bits are set again, and it then restarts with the high phase.
- R7: When the duty count is greater than or equal to the period count, the output stays high through the whole period.
- R8: Duty, period and prescale values written while a channel runs take effect at the next period start. A write that lands on the same clock edge as a period end applies one period later.
- R9: Reads from unmapped addresses return zero and writes to them change no register. Unmapped addresses include offset 12 of channels 0 to 2, any address from 64 up, and any misaligned address.
- R10: Each channel keeps its own timing while the others run or are reprogrammed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the bus and all counters |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe; the write happens at the next rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, valid in the same cycle |
| pwm_o | output | 4 | One modulated output per channel |

## Verification
A register write and a period end can fall on the same clock edge. The bench provokes this by waiting for a rising output edge and then timing a duty write so that it commits on the exact edge where the period wraps. It repeats the write one cycle earlier. In the coincident case, the next high phase must still have the old length. In the early case, it must already have the new length. Together these results pin the shadow reload to the period boundary.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int unsigned PSC_W  = 14;
    localparam int unsigned CNT_W  = 16;
    localparam int unsigned CTRL_W = PSC_W + 2;

    localparam logic [3:0] OFF_CTRL = 4'h0;
    localparam logic [3:0] OFF_DUTY = 4'h4;
    localparam logic [3:0] OFF_PER  = 4'h8;

    typedef struct packed {
        logic             en;
        logic [PSC_W-1:0] psc;
        logic [CNT_W-1:0] duty;
        logic [CNT_W-1:0] per;
    } chan_cfg_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int unsigned NUM_CH      = 4,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned MASTER_ADDR = 'h3C
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic                         bus_we,
    input  logic [DATA_W-1:0]            bus_wdata,
    output logic [DATA_W-1:0]            bus_rdata,
    output chan_cfg_t [NUM_CH-1:0]       cfg_o
);
    localparam int unsigned IDX_W = ADDR_W - 4;

    typedef struct packed {
        logic [NUM_CH-1:0][CTRL_W-1:0] ctrl;
        logic [NUM_CH-1:0][CNT_W-1:0]  duty;
        logic [NUM_CH-1:0][CNT_W-1:0]  per;
        logic                          master;
    } regs_t;

    regs_t             r_q, r_d;
    logic [IDX_W-1:0]  idx;
    logic [3:0]        off;
    logic [NUM_CH-1:0] ch_sel;
    logic              off_ok, ch_hit, mst_hit;
    logic              unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-1:CTRL_W];

    // address decode
    always_comb begin
        idx = bus_addr[ADDR_W-1:4];
        off = bus_addr[3:0];
        for (int c = 0; c < NUM_CH; c++) begin
            ch_sel[c] = (idx == IDX_W'(c));
        end
        off_ok  = (off == OFF_CTRL) || (off == OFF_DUTY) || (off == OFF_PER);
        ch_hit  = (|ch_sel) && off_ok;
        mst_hit = (bus_addr == ADDR_W'(MASTER_ADDR));
    end

    // next register state and read mux
    always_comb begin
        r_d       = r_q;
        bus_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_sel[c] && off_ok) begin
                if (off == OFF_CTRL) begin
                    bus_rdata = DATA_W'(r_q.ctrl[c]);
                    if (bus_we) r_d.ctrl[c] = bus_wdata[CTRL_W-1:0];
                end else if (off == OFF_DUTY) begin
                    bus_rdata = DATA_W'(r_q.duty[c]);
                    if (bus_we) r_d.duty[c] = bus_wdata[CNT_W-1:0];
                end else begin
                    bus_rdata = DATA_W'(r_q.per[c]);
                    if (bus_we) r_d.per[c] = bus_wdata[CNT_W-1:0];
                end
            end
        end
        if (mst_hit) begin
            bus_rdata = DATA_W'(r_q.master);
            if (bus_we) r_d.master = bus_wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_cfg
        assign cfg_o[g].en   = r_q.ctrl[g][0] & r_q.master;
        assign cfg_o[g].psc  = r_q.ctrl[g][CTRL_W-1:2];
        assign cfg_o[g].duty = r_q.duty[g];
        assign cfg_o[g].per  = r_q.per[g];
    end

    // R9
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !ch_hit && !mst_hit) |=> $stable(r_q));

    // R9
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ch_hit && !mst_hit) |-> (bus_rdata == '0));

    // R2
    master_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && mst_hit) |=> (r_q.master == $past(bus_wdata[0])));
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  chan_cfg_t cfg_i,
    output logic      pwm_o
);
    typedef struct packed {
        logic             live;
        logic [PSC_W-1:0] psc_lim;
        logic [PSC_W-1:0] psc_cnt;
        logic [CNT_W-1:0] last;
        logic [CNT_W-1:0] duty;
        logic [CNT_W-1:0] pos;
        logic             out;
    } st_t;

    st_t              s_q, s_d;
    logic             tick, wrap;
    logic [CNT_W-1:0] last_new;

    always_comb begin
        // a period count of zero behaves as one
        last_new = (cfg_i.per == '0) ? '0 : cfg_i.per - CNT_W'(1);
        tick     = (s_q.psc_cnt == s_q.psc_lim);
        wrap     = tick && (s_q.pos == s_q.last);
        s_d      = s_q;
        if (!cfg_i.en) begin
            s_d = '0;
        end else if (!s_q.live || wrap) begin
            s_d.live    = 1'b1;
            s_d.psc_lim = cfg_i.psc;
            s_d.psc_cnt = '0;
            s_d.last    = last_new;
            s_d.duty    = cfg_i.duty;
            s_d.pos     = '0;
        end else if (tick) begin
            s_d.psc_cnt = '0;
            s_d.pos     = s_q.pos + CNT_W'(1);
        end else begin
            s_d.psc_cnt = s_q.psc_cnt + PSC_W'(1);
        end
        s_d.out = s_d.live && (s_d.pos < s_d.duty);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pwm_o = s_q.out;

    // R6
    off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_i.en |=> (!pwm_o && !s_q.live && s_q.pos == '0));

    // R4
    pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.live |-> (s_q.pos <= s_q.last && s_q.psc_cnt <= s_q.psc_lim));

    // R8
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.live && cfg_i.en && !wrap) |=> ($stable(s_q.duty) && $stable(s_q.last)
                                              && $stable(s_q.psc_lim)));

    // R7
    full_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.live && cfg_i.en && !wrap && s_q.duty > s_q.last) |=> pwm_o);
endmodule

// File: rtl/pwm_multi.sv
module pwm_multi
    import pwm_pkg::*;
#(
    parameter int unsigned NUM_CH      = 4,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned MASTER_ADDR = 'h3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] pwm_o
);
    chan_cfg_t [NUM_CH-1:0] cfg;

    pwm_regs #(
        .NUM_CH      (NUM_CH),
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .MASTER_ADDR (MASTER_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cfg_o     (cfg)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_chan u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .cfg_i (cfg[g]),
            .pwm_o (pwm_o[g])
        );
    end
endmodule

// File: tb/tb_pwm_multi.sv
module tb_pwm_multi;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr;
    logic        we;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [3:0]  pwm;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    pwm_multi dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
        .bus_wdata(wdata), .bus_rdata(rdata), .pwm_o(pwm)
    );

    // {channel, prescale, duty, period}
    localparam int NV = 6;
    localparam logic [47:0] VEC [NV] = '{
        {2'd0, 14'd0,  16'd1, 16'd2},
        {2'd1, 14'd0,  16'd3, 16'd10},
        {2'd2, 14'd2,  16'd5, 16'd8},
        {2'd3, 14'd4,  16'd7, 16'd9},
        {2'd0, 14'd1,  16'd9, 16'd10},
        {2'd1, 14'd13, 16'd2, 16'd3}
    };

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0; addr = 8'h40;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
        addr = a; we = 1'b0;
        #1;
        chk(rdata == exp, req, rdata, exp);
        addr = 8'h40;
    endtask

    task automatic wait_rise(input int ch, output bit ok);
        bit prev;
        prev = pwm[ch];
        ok = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (!prev && pwm[ch]) begin
                ok = 1'b1;
                break;
            end
            prev = pwm[ch];
        end
    endtask

    // from the current sample: skip low samples, then count high samples
    task automatic count_hi(input int ch, output int hi);
        int g;
        hi = 0; g = 0;
        while (!pwm[ch] && g < 4000) begin @(negedge clk); g++; end
        while (pwm[ch] && g < 4000) begin hi++; g++; @(negedge clk); end
        if (g >= 4000) hi = -1;
    endtask

    task automatic measure(input int ch, output int hi, output int per);
        bit ok;
        int lo, g;
        hi = 0; lo = 0; g = 0;
        wait_rise(ch, ok);
        while (ok && pwm[ch] && g < 4000) begin hi++; g++; @(negedge clk); end
        while (ok && !pwm[ch] && g < 4000) begin lo++; g++; @(negedge clk); end
        per = hi + lo;
        if (!ok || g >= 4000) begin hi = -1; per = -1; end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int hi, per, lows;
        bit ok;
        addr = 8'h40; we = 1'b0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int c = 0; c < 4; c++) begin
            rd_chk(8'(c * 16),     32'h0, "R1 ctrl");
            rd_chk(8'(c * 16 + 4), 32'h0, "R1 duty");
            rd_chk(8'(c * 16 + 8), 32'h0, "R1 period");
        end
        rd_chk(8'h3C, 32'h0, "R1 master");
        chk(pwm == 4'h0, "R1 outputs", pwm, 0);

        // R9 unmapped writes ignored, reads zero
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h1C, 32'hFFFF_FFFF);
        wr(8'h2C, 32'hFFFF_FFFF);
        wr(8'h40, 32'hFFFF_FFFF);
        wr(8'h02, 32'hFFFF_FFFF);
        wr(8'h35, 32'hFFFF_FFFF);
        rd_chk(8'h0C, 32'h0, "R9 read 0x0C");
        rd_chk(8'h2C, 32'h0, "R9 read 0x2C");
        rd_chk(8'h40, 32'h0, "R9 read 0x40");
        rd_chk(8'h35, 32'h0, "R9 read 0x35");
        for (int c = 0; c < 4; c++) begin
            rd_chk(8'(c * 16),     32'h0, "R9 ctrl untouched");
            rd_chk(8'(c * 16 + 4), 32'h0, "R9 duty untouched");
            rd_chk(8'(c * 16 + 8), 32'h0, "R9 period untouched");
        end
        rd_chk(8'h3C, 32'h0, "R9 master untouched");
        chk(pwm == 4'h0, "R9 outputs low", pwm, 0);

        // R2 / R3 readback and field layout
        wr(8'h10, 32'hFFFF_FFFF);
        rd_chk(8'h10, 32'h0000_FFFF, "R2 ctrl readback");
        wr(8'h14, 32'hFFFF_FFFF);
        rd_chk(8'h14, 32'h0000_FFFF, "R2 duty readback");
        wr(8'h18, 32'h1234_ABCD);
        rd_chk(8'h18, 32'h0000_ABCD, "R2 period readback");
        wr(8'h20, 32'h0000_A5A6);
        rd_chk(8'h20, 32'h0000_A5A6, "R3 ctrl bit1 and prescale readback");
        rd_chk(8'h00, 32'h0, "R2 neighbour channel unaffected");
        chk(pwm == 4'h0, "R6 enabled channel silent without master", pwm, 0);
        wr(8'h3C, 32'hFFFF_FFFE);
        rd_chk(8'h3C, 32'h0, "R2 master keeps bit0 only");
        wr(8'h10, 0); wr(8'h14, 0); wr(8'h18, 0); wr(8'h20, 0);

        // R6 master gating
        wr(8'h08, 4); wr(8'h04, 2); wr(8'h00, 1);
        lows = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (pwm[0]) lows++; end
        chk(lows == 0, "R6 no output while master clear", lows, 0);
        wr(8'h3C, 1);
        measure(0, hi, per);
        chk(hi == 2, "R5 high time with master set", hi, 2);
        chk(per == 4, "R4 period with master set", per, 4);
        wr(8'h3C, 0);
        @(negedge clk);
        lows = 0;
        for (int i = 0; i < 10; i++) begin if (pwm[0]) lows++; @(negedge clk); end
        chk(lows == 0, "R6 output low after master clear", lows, 0);
        wr(8'h3C, 1);
        @(negedge clk);
        chk(pwm[0] == 1'b1, "R6 restart begins with high phase", pwm[0], 1);
        wr(8'h00, 0);
        @(negedge clk);
        chk(pwm[0] == 1'b0, "R6 output low after channel disable", pwm[0], 0);

        // table: earlier channels keep running (R10)
        for (int v = 0; v < NV; v++) begin
            logic [1:0]  vc;
            logic [13:0] vp;
            logic [15:0] vd, vr;
            {vc, vp, vd, vr} = VEC[v];
            wr(8'(int'(vc) * 16 + 8), 32'(vr));
            wr(8'(int'(vc) * 16 + 4), 32'(vd));
            wr(8'(int'(vc) * 16), {16'h0, vp, 2'b01});
            rd_chk(8'(int'(vc) * 16), {16'h0, vp, 2'b01}, "R3 ctrl word in table");
            measure(int'(vc), hi, per);
            chk(hi == (int'(vp) + 1) * int'(vd), "R5 table high time", hi, (int'(vp) + 1) * int'(vd));
            chk(per == (int'(vp) + 1) * int'(vr), "R4 table period", per, (int'(vp) + 1) * int'(vr));
        end
        measure(3, hi, per);
        chk(hi == 35 && per == 45, "R10 channel 3 unchanged by others", per, 45);
        measure(2, hi, per);
        chk(hi == 15 && per == 24, "R10 channel 2 unchanged by others", per, 24);
        for (int c = 0; c < 4; c++) wr(8'(c * 16), 0);
        @(negedge clk);
        chk(pwm == 4'h0, "R6 all channels off", pwm, 0);

        // R7 duty >= period
        wr(8'h28, 5); wr(8'h24, 5); wr(8'h20, {16'h0, 14'd1, 2'b01});
        @(negedge clk);
        lows = 0;
        for (int i = 0; i < 30; i++) begin if (!pwm[2]) lows++; @(negedge clk); end
        chk(lows == 0, "R7 duty equal to period stays high", lows, 0);
        wr(8'h24, 9);
        repeat (30) @(negedge clk);
        lows = 0;
        for (int i = 0; i < 30; i++) begin if (!pwm[2]) lows++; @(negedge clk); end
        chk(lows == 0, "R7 duty above period stays high", lows, 0);
        wr(8'h20, 0);

        // R8 writes landing one cycle before and exactly on the period end
        wr(8'h18, 10); wr(8'h14, 3); wr(8'h10, 1);
        wait_rise(1, ok);
        repeat (8) @(negedge clk);
        wr(8'h14, 6);
        count_hi(1, hi);
        chk(hi == 6, "R8 write before boundary takes effect", hi, 6);
        wait_rise(1, ok);
        repeat (9) @(negedge clk);
        wr(8'h14, 2);
        count_hi(1, hi);
        chk(hi == 6, "R8 write on boundary keeps old duty", hi, 6);
        measure(1, hi, per);
        chk(hi == 2 && per == 10, "R8 new duty in following period", hi, 2);
        wr(8'h18, 16);
        measure(1, hi, per);
        chk(hi == 2 && per == 16, "R8 new period at next boundary", per, 16);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule